// File: doc/BRIEF.md
# Limit-Compare Interval Timer Array

This block holds one shared channel and a parameterised set of per-processor channels, each a 21-bit up-counter checked against a programmable limit. When the counter gets to its limit it goes back to 1 and sets a sticky limit-reached flag. That flag is the channel's interrupt output. A per-processor channel interrupts only its own processor. The shared channel raises a broadcast interrupt that every processor sees.

All counters advance on a single-cycle tick pulse supplied from outside. Software reaches the channels through a simple 32-bit word-addressed bus. Each channel occupies four consecutive words: limit, count, limit-without-restart and control. Read data is registered. A read of the limit word acknowledges the interrupt.

The value fields sit in bits 30:10 of the data word. Bit 31 carries the flag, and bits 9:0 read as zero.

Top module: `limit_timer_array`

## Requirements
- R1: After reset, every per-processor limit word reads 0x009C4000 and the shared limit word reads 0. Every count word reads 0x00000400 (count 1) and every control word reads 0. All interrupt outputs are low.
- R2: A write to word offset 0 (limit) loads wdata bits 30:10 as the limit. It sets the count to 1 and clears the flag and the interrupt. Data bits 31 and 9:0 are dropped.
- R3: Each tick pulse on a running channel adds 1 to the count field, which is 0x400 in the word. Without a tick the count does not change.
- R4: The wrap rule is checked against the old count. On a tick where count+1 is greater than or equal to the limit, the count becomes 1 and the flag is set. A limit of L therefore raises the flag L-1 ticks after the count was 1.
- R5: The flag of per-processor channel i drives irq_cpu_o[i] only. The shared channel's flag drives every bit of irq_bcast_o.
- R6: Reads of offsets 0 (limit) and 1 (count) return the flag in bit 31 and the field in bits 30:10. A limit read clears the flag after returning it. A count read leaves the flag unchanged. If a limit read and a wrap fall in the same cycle, the flag ends up set.
- R7: A write to offset 2 (limit-without-restart) loads the limit and leaves the count and the flag unchanged. A read of offset 2 returns the same value as a limit read, with no side effect.
- R8: A channel whose limit is 0 does not count and does not raise its flag.
- R9: Control word bit 0 (offset 3) must be 1 for a per-processor channel to count. It resets to 0. The shared channel always counts, and its control word reads 0 and ignores writes.
- R10: The word address is split into a block index (addr_i bits above 1) and an offset (addr_i[1:0]). Per-processor channel i is block i, and the shared channel is block N_CPU. Reads of any other block return 0.
- R11: rdata_o changes only on the clock edge that accepts a read, and it shows that read's data from then until the next read.
- R12: A write to offset 1 (count) loads wdata bits 30:10 into the count and leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle count enable from the prescaler |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_cpu_o | output | N_CPU | Per-processor interrupt, one bit per processor |
| irq_bcast_o | output | N_CPU | Shared-channel interrupt copied to every processor |

## Verification
Every result of this block is due one clock edge after its stimulus. A tick, a write or a read-acknowledge changes the count, the flag and both interrupt buses at the edge that accepts it. Read data becomes visible on rdata_o at that same edge, and it carries the flag value from before any clear that the read causes. The bench applies each stimulus for one cycle at a falling edge and samples at the next falling edge, after exactly one rising edge. The same-edge cases are driven in a single cycle: a read together with a wrap, and a limit-without-restart write checked against a running count.

// File: rtl/limit_timer_pkg.sv
package limit_timer_pkg;
  localparam int VAL_W    = 21;
  localparam int VAL_LSB  = 10;
  localparam int FLAG_BIT = 31;
  localparam int OFF_W    = 2;

  typedef enum logic [OFF_W-1:0] {
    OFF_LIMIT = 2'd0,
    OFF_COUNT = 2'd1,
    OFF_NOCLR = 2'd2,
    OFF_CTRL  = 2'd3
  } reg_off_e;

  localparam logic [VAL_W-1:0] CPU_RST_LIM = 21'h002710;

  function automatic logic [31:0] pack_word(input logic flag, input logic [VAL_W-1:0] val);
    return {flag, val, {VAL_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/timer_regdec.sv
module timer_regdec
  import limit_timer_pkg::*;
#(
  parameter int N_BLK  = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_BLK-1:0]  sel_o,
  output reg_off_e          off_o
);
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [BLK_W-1:0] blk;
  assign blk   = addr_i[ADDR_W-1:OFF_W];
  assign off_o = reg_off_e'(addr_i[OFF_W-1:0]);

  for (genvar b = 0; b < N_BLK; b++) begin : g_sel
    assign sel_o[b] = req_i && (blk == BLK_W'(b));
  end

  // R10: at most one block selected per access
  p_sel_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_sel_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (sel_o == '0));
endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import limit_timer_pkg::*;
#(
  parameter bit               IS_CPU  = 1'b1,
  parameter logic [VAL_W-1:0] RST_LIM = CPU_RST_LIM
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        sel_i,
  input  logic        we_i,
  input  reg_off_e    off_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        flag_o
);
  logic [VAL_W-1:0] lim_q, cnt_q;
  logic             flag_q, en_q;
  logic [VAL_W-1:0] wval;
  logic             wr, rd, run, wrap;
  logic             unused_wbits;

  assign wval         = wdata_i[FLAG_BIT-1:VAL_LSB];
  assign unused_wbits = ^{wdata_i[FLAG_BIT], wdata_i[VAL_LSB-1:1]};
  assign wr           = sel_i && we_i;
  assign rd           = sel_i && !we_i;
  assign run          = (lim_q != '0) && (IS_CPU ? en_q : 1'b1);
  // compare against old count; >= also recovers from a lowered limit
  assign wrap         = tick_i && run && (({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= RST_LIM;
      cnt_q  <= VAL_W'(1);
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (wr && off_i == OFF_LIMIT) begin
        lim_q  <= wval;
        cnt_q  <= VAL_W'(1);
        flag_q <= 1'b0;
      end else begin
        if (wr && off_i == OFF_NOCLR) lim_q <= wval;
        if (wr && off_i == OFF_COUNT) cnt_q <= wval;
        else if (tick_i && run)       cnt_q <= wrap ? VAL_W'(1) : cnt_q + 1'b1;
        // set wins over the read acknowledge
        if (wrap)                             flag_q <= 1'b1;
        else if (rd && off_i == OFF_LIMIT)    flag_q <= 1'b0;
      end
      if (IS_CPU && wr && off_i == OFF_CTRL) en_q <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_LIMIT, OFF_NOCLR: rdata_o = pack_word(flag_q, lim_q);
      OFF_COUNT:            rdata_o = pack_word(flag_q, cnt_q);
      default:              rdata_o = {31'b0, IS_CPU ? en_q : 1'b0};
    endcase
  end

  assign flag_o = flag_q;

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && run && !wrap && !sel_i |=> cnt_q == $past(cnt_q) + 1'b1);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr |=> $stable(cnt_q));
  p_lim_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && off_i == OFF_LIMIT |=> cnt_q == VAL_W'(1) && !flag_q);
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap && !sel_i |=> cnt_q == VAL_W'(1) && flag_q);
  p_rdclr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && off_i == OFF_LIMIT && !tick_i |=> !flag_q);
  p_noclr_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && off_i == OFF_NOCLR && !tick_i |=> $stable(cnt_q) && $stable(flag_q));
  p_zero_lim_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_q == '0 && !sel_i |=> $stable(cnt_q) && $stable(flag_q));
  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    IS_CPU && !en_q && !sel_i |=> $stable(cnt_q));
endmodule

// File: rtl/limit_timer_array.sv
module limit_timer_array
  import limit_timer_pkg::*;
#(
  parameter int N_CPU  = 2,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [N_CPU-1:0]  irq_cpu_o,
  output logic [N_CPU-1:0]  irq_bcast_o
);
  localparam int N_BLK = N_CPU + 1;

  logic [N_BLK-1:0] sel;
  reg_off_e         off;
  logic [31:0]      blk_rd [N_BLK];
  logic [N_BLK-1:0] blk_flag;
  logic [31:0]      rd_mux;

  timer_regdec #(.N_BLK(N_BLK), .ADDR_W(ADDR_W)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .addr_i(addr_i),
    .sel_o (sel),
    .off_o (off)
  );

  for (genvar b = 0; b < N_BLK; b++) begin : g_chan
    localparam bit IS_CPU = (b < N_CPU);
    timer_chan #(
      .IS_CPU (IS_CPU),
      .RST_LIM(IS_CPU ? CPU_RST_LIM : '0)
    ) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .sel_i  (sel[b]),
      .we_i   (we_i),
      .off_i  (off),
      .wdata_i(wdata_i),
      .rdata_o(blk_rd[b]),
      .flag_o (blk_flag[b])
    );
  end

  assign irq_cpu_o   = blk_flag[N_CPU-1:0];
  assign irq_bcast_o = {N_CPU{blk_flag[N_CPU]}};

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < N_BLK; b++) begin
      if (sel[b]) rd_mux = rd_mux | blk_rd[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= rd_mux;
  end

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && sel == '0 |=> rdata_o == '0);
  p_low_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && !we_i && addr_i[1:0] != 2'd3) |-> rdata_o[VAL_LSB-1:0] == '0);
endmodule

// File: tb/tb_limit_timer_array.sv
module tb_limit_timer_array;
  localparam int N_CPU  = 2;
  localparam int ADDR_W = 6;
  localparam int N_VEC  = 31;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_TK = 2'd2;

  // {req tag, op, addr, data/ticks, expected}
  localparam logic [77:0] VEC [N_VEC] = '{
    {4'd1,  OP_RD, 8'd0,  32'h0,        32'h009C4000},  // R1
    {4'd1,  OP_RD, 8'd1,  32'h0,        32'h00000400},  // R1
    {4'd1,  OP_RD, 8'd3,  32'h0,        32'h00000000},  // R1
    {4'd1,  OP_RD, 8'd4,  32'h0,        32'h009C4000},  // R1
    {4'd2,  OP_WR, 8'd0,  32'h00001400, 32'h0},
    {4'd9,  OP_WR, 8'd3,  32'h00000001, 32'h0},
    {4'd9,  OP_RD, 8'd3,  32'h0,        32'h00000001},  // R9
    {4'd3,  OP_TK, 8'd0,  32'd1,        32'h0},
    {4'd3,  OP_RD, 8'd1,  32'h0,        32'h00000800},  // R3
    {4'd3,  OP_TK, 8'd0,  32'd2,        32'h0},
    {4'd3,  OP_RD, 8'd1,  32'h0,        32'h00001000},  // R3
    {4'd4,  OP_TK, 8'd0,  32'd1,        32'h0},
    {4'd4,  OP_RD, 8'd1,  32'h0,        32'h80000400},  // R4, count read keeps flag
    {4'd6,  OP_RD, 8'd0,  32'h0,        32'h80001400},  // R6
    {4'd6,  OP_RD, 8'd0,  32'h0,        32'h00001400},  // R6 cleared
    {4'd7,  OP_TK, 8'd0,  32'd2,        32'h0},
    {4'd7,  OP_WR, 8'd2,  32'h00002000, 32'h0},
    {4'd7,  OP_RD, 8'd1,  32'h0,        32'h00000C00},  // R7
    {4'd7,  OP_RD, 8'd2,  32'h0,        32'h00002000},  // R7
    {4'd2,  OP_WR, 8'd0,  32'h00002000, 32'h0},
    {4'd2,  OP_RD, 8'd1,  32'h0,        32'h00000400},  // R2
    {4'd9,  OP_WR, 8'd3,  32'h00000000, 32'h0},
    {4'd9,  OP_TK, 8'd0,  32'd1,        32'h0},
    {4'd9,  OP_RD, 8'd1,  32'h0,        32'h00000400},  // R9
    {4'd8,  OP_RD, 8'd8,  32'h0,        32'h00000000},  // R8
    {4'd8,  OP_RD, 8'd9,  32'h0,        32'h00000400},  // R8
    {4'd10, OP_RD, 8'd12, 32'h0,        32'h00000000},  // R10
    {4'd12, OP_WR, 8'd1,  32'hFFFFFFFF, 32'h0},
    {4'd12, OP_RD, 8'd1,  32'h0,        32'h7FFFFC00},  // R12
    {4'd2,  OP_WR, 8'd0,  32'hFFFFFFFF, 32'h0},
    {4'd2,  OP_RD, 8'd0,  32'h0,        32'h7FFFFC00}   // R2
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [N_CPU-1:0]  irq_cpu, irq_bcast;
  int                n_chk = 0, n_fail = 0;
  bit                done = 1'b0;

  always #5 clk = ~clk;

  limit_timer_array #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_cpu_o(irq_cpu), .irq_bcast_o(irq_bcast)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // one-cycle access; returns at the falling edge after the accepting rising edge
  task automatic cyc(input logic r, input logic w, input logic [ADDR_W-1:0] a,
                     input logic [31:0] d, input logic t);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; tick = t;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    cyc(1'b1, 1'b0, a, '0, 1'b0);
    check(tag, rdata, exp);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, '0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq_cpu", 32'(irq_cpu), 32'h0);
    check("R1 irq_bcast", 32'(irq_bcast), 32'h0);

    for (int v = 0; v < N_VEC; v++) begin
      logic [3:0]  tag = VEC[v][77:74];
      logic [1:0]  op  = VEC[v][73:72];
      logic [7:0]  a   = VEC[v][71:64];
      logic [31:0] d   = VEC[v][63:32];
      logic [31:0] e   = VEC[v][31:0];
      case (op)
        OP_WR:   wr(a[ADDR_W-1:0], d);
        OP_TK:   tk(int'(d));
        default: rd($sformatf("R%0d vec %0d", tag, v), a[ADDR_W-1:0], e);
      endcase
    end

    // R5: per-processor routing, channel 1 with limit 2
    wr(6'd4, 32'h00000800);
    wr(6'd7, 32'h1);
    tk(1);
    check("R5 cpu1 irq", 32'(irq_cpu), 32'h2);
    check("R5 bcast quiet", 32'(irq_bcast), 32'h0);
    rd("R6 ack cpu1", 6'd4, 32'h80000800);
    check("R6 irq cleared", 32'(irq_cpu), 32'h0);
    wr(6'd7, 32'h0);

    // R4: limit 4 raises the flag on the third tick
    wr(6'd0, 32'h00001000);
    wr(6'd3, 32'h1);
    tk(2);
    check("R4 early", 32'(irq_cpu), 32'h0);
    tk(1);
    check("R4 period", 32'(irq_cpu), 32'h1);
    rd("R6 ack cpu0", 6'd0, 32'h80001000);
    wr(6'd3, 32'h0);

    // R5/R9: shared channel runs without control, broadcasts
    wr(6'd11, 32'h1);
    rd("R9 shared ctrl", 6'd11, 32'h0);
    wr(6'd8, 32'h00000C00);
    tk(1);
    check("R5 bcast early", 32'(irq_bcast), 32'h0);
    tk(1);
    check("R5 bcast all", 32'(irq_bcast), 32'h3);
    check("R5 cpu quiet", 32'(irq_cpu), 32'h0);

    // R6: read-acknowledge and wrap in the same cycle; set wins
    wr(6'd8, 32'h00000800);
    check("R2 shared clear", 32'(irq_bcast), 32'h0);
    cyc(1'b1, 1'b0, 6'd8, '0, 1'b1);
    check("R6 same-cycle data", rdata, 32'h00000800);
    check("R6 same-cycle irq", 32'(irq_bcast), 32'h3);
    rd("R6 flag kept", 6'd9, 32'h80000400);

    // R11: writes and idle cycles leave rdata unchanged
    wr(6'd0, 32'h00000400);
    tk(1);
    check("R11 hold", rdata, 32'h80000400);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 bcast after reset", 32'(irq_bcast), 32'h0);
    rd("R1 shared limit", 6'd8, 32'h0);
    rd("R1 cpu0 limit", 6'd0, 32'h009C4000);
    rd("R1 cpu1 ctrl", 6'd7, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule